// File: doc/BRIEF.md
# NAND Sector Hamming ECC Generator

This block forms a single-error-correcting Hamming parity code over one 512-byte NAND sector. Bytes are offered on a valid/data pair, and each accepted byte is given a 9-bit index inside the sector. Every data bit therefore has a 12-bit bit address: the byte index in the upper nine bits and the bit-in-byte position in the lower three. For each of the twelve address lines the block keeps two running parities. One covers all set data bits whose address line is 1 ("one" group). The other covers all set data bits whose address line is 0 ("zero" group).

Software arms the block by writing the control word with bit 8 set, streams the sector through, and then reads the result word. The "zero" group sits in the low half of the result word and the "one" group in the upper half. A read clears the accumulation. For storage in the spare area the block also keeps a packed 24-bit code: the two groups placed next to each other and bitwise inverted, so that an erased sector (all bytes 0xFF) yields an all-ones code. Software reading the result compares the stored and recomputed codes. If their XOR has complementary halves, the "one" half of the XOR gives the address of the failing bit.

Top module: `nand_ecc_gen`

## Requirements
- R1: After synchronous reset, `ecc_reg_o` is 0, `code_o` is 24'hFFFFFF, `done_o` is 0, and the block is not armed.
- R2: A cycle with `ctl_we_i`=1 and `ctl_wdata_i[8]`=1 clears both parity groups, the byte index and `done_o`, and arms the block. A control write with bit 8 at 0 has no effect. Bytes offered before the first arming leave `ecc_reg_o` at 0.
- R3: `ecc_reg_o[27:16]` bit k is the XOR of every accepted data bit whose 12-bit address {byte_index[8:0], bit_in_byte[2:0]} has bit k set.
- R4: `ecc_reg_o[11:0]` bit k is the XOR of every accepted data bit whose address has bit k clear. Bits 15:12 and 31:28 read 0.
- R5: `code_o` equals ~{ecc_reg_o[27:16], ecc_reg_o[11:0]}, with the first byte for the spare area in `code_o[7:0]` and the last in `code_o[23:16]`. It is updated in the same cycle as `ecc_reg_o`.
- R6: A sector of 512 bytes of 0xFF, or of 0x00, gives `code_o` = 24'hFFFFFF.
- R7: A byte is taken only in a cycle with `in_valid_i`=1. Idle cycles between bytes change neither the result nor the byte index.
- R8: `done_o` goes high in the cycle after the 512th byte is accepted. Further bytes are ignored until the next arming or read.
- R9: In a cycle with `rd_i`=1, `ecc_reg_o` shows the accumulated result. From the next cycle the parities are 0, the byte index restarts at 0 and `done_o` is 0, while the block stays armed. A byte offered in the read cycle is discarded.
- R10: Arming in the middle of a sector discards the partial result and restarts the byte index at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word; bit 8 arms and clears |
| rd_i | input | 1 | Result read strobe; clears after the read |
| in_valid_i | input | 1 | Data byte valid |
| in_data_i | input | 8 | Data byte |
| ecc_reg_o | output | 32 | Result word: zero group [11:0], one group [27:16] |
| code_o | output | 24 | Packed inverted code, spare-area byte 0 in [7:0] |
| done_o | output | 1 | Full sector accumulated |

## Verification
Constant sectors of 0xFF and 0x00 must both give the all-ones code; they show that even counts cancel and that the inversion is present. Single set bits on a zero background at the first, the last and middle addresses put the bit address in one half of the result and its complement in the other. This separates the two groups and exposes any swapped or shifted address line. A single cleared bit in an erased sector must give the same code as the set bit at that address. An incrementing-byte sector mixes every row and column parity, and some sectors are sent with idle gaps to show that only valid cycles count. Directed runs cover arming, the 512-byte limit, a byte that collides with a read, and a restart in the middle of a sector.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned HI_OFS    = 16;
  localparam int unsigned START_BIT = 8;

  // Parity group width: bit-in-byte lines plus byte-index lines.
  function automatic int unsigned grp_width(input int unsigned data_w,
                                            input int unsigned sector_bytes);
    return $clog2(data_w) + $clog2(sector_bytes);
  endfunction
endpackage

// File: rtl/ecc_byte_contrib.sv
module ecc_byte_contrib #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 9
) (
  input  logic [DATA_W-1:0]                  data_i,
  input  logic [IDX_W-1:0]                   idx_i,
  output logic [$clog2(DATA_W)+IDX_W-1:0]    one_o,
  output logic [$clog2(DATA_W)+IDX_W-1:0]    zero_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] line_mask(input int unsigned k);
    logic [DATA_W-1:0] m;
    for (int unsigned j = 0; j < DATA_W; j++) m[j] = ((j >> k) & 1) != 0;
    return m;
  endfunction

  logic row_par;
  assign row_par = ^data_i;

  genvar g;
  generate
    for (g = 0; g < BIT_W; g++) begin : g_col
      localparam logic [DATA_W-1:0] MASK = line_mask(g);
      assign one_o[g]  = ^(data_i & MASK);
      assign zero_o[g] = ^(data_i & ~MASK);
    end
    for (g = 0; g < IDX_W; g++) begin : g_row
      assign one_o[BIT_W+g]  = row_par & idx_i[g];
      assign zero_o[BIT_W+g] = row_par & ~idx_i[g];
    end
  endgenerate
endmodule

// File: rtl/ecc_sector_ctl.sv
module ecc_sector_ctl #(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start_i,
  input  logic                            rd_clr_i,
  input  logic                            in_valid_i,
  output logic                            accept_o,
  output logic [$clog2(SECTOR_BYTES)-1:0] idx_o,
  output logic                            done_o
);
  localparam int unsigned IDX_W = $clog2(SECTOR_BYTES);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SECTOR_BYTES - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             full;

  assign full     = (cnt_q == FULL_CNT);
  assign accept_o = in_valid_i & armed_q & ~full & ~start_i & ~rd_clr_i;
  assign idx_o    = cnt_q[IDX_W-1:0];
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (rd_clr_i) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (accept_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_CNT) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
  parameter int unsigned GW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          accept_i,
  input  logic [GW-1:0] one_c_i,
  input  logic [GW-1:0] zero_c_i,
  output logic [GW-1:0] one_q_o,
  output logic [GW-1:0] zero_q_o,
  output logic [2*GW-1:0] code_q_o
);
  logic [GW-1:0] one_n, zero_n;

  always_comb begin
    one_n  = one_q_o ^ one_c_i;
    zero_n = zero_q_o ^ zero_c_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      one_q_o  <= '0;
      zero_q_o <= '0;
      code_q_o <= '1;
    end else if (accept_i) begin
      one_q_o  <= one_n;
      zero_q_o <= zero_n;
      code_q_o <= ~{one_n, zero_n};
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctl_we_i,
  input  logic [REG_W-1:0]      ctl_wdata_i,
  input  logic                  rd_i,
  input  logic                  in_valid_i,
  input  logic [DATA_W-1:0]     in_data_i,
  output logic [REG_W-1:0]      ecc_reg_o,
  output logic [2*grp_width(DATA_W, SECTOR_BYTES)-1:0] code_o,
  output logic                  done_o
);
  localparam int unsigned IDX_W = $clog2(SECTOR_BYTES);
  localparam int unsigned GW    = grp_width(DATA_W, SECTOR_BYTES);

  logic             start;
  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [GW-1:0]    one_c, zero_c, one_q, zero_q;
  logic [REG_W-1:0] unused_ctl_bits;

  assign start           = ctl_we_i & ctl_wdata_i[START_BIT];
  assign unused_ctl_bits = ctl_wdata_i;

  ecc_sector_ctl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .rd_clr_i  (rd_i),
    .in_valid_i(in_valid_i),
    .accept_o  (accept),
    .idx_o     (idx),
    .done_o    (done_o)
  );

  ecc_byte_contrib #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_contrib (
    .data_i(in_data_i),
    .idx_i (idx),
    .one_o (one_c),
    .zero_o(zero_c)
  );

  ecc_accum #(.GW(GW)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start | rd_i),
    .accept_i(accept),
    .one_c_i (one_c),
    .zero_c_i(zero_c),
    .one_q_o (one_q),
    .zero_q_o(zero_q),
    .code_q_o(code_o)
  );

  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : g_reg
      if (b < GW) begin : g_zero
        assign ecc_reg_o[b] = zero_q[b];
      end else if (b >= HI_OFS && b < HI_OFS + GW) begin : g_one
        assign ecc_reg_o[b] = one_q[b-HI_OFS];
      end else begin : g_pad
        assign ecc_reg_o[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SECTOR_BYTES = 512
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ctl_we_i,
  input logic                  start_bit_i,
  input logic                  rd_i,
  input logic                  in_valid_i,
  input logic [REG_W-1:0]      ecc_reg_o,
  input logic [2*grp_width(DATA_W, SECTOR_BYTES)-1:0] code_o,
  input logic                  done_o
);
  localparam int unsigned GW = grp_width(DATA_W, SECTOR_BYTES);

  logic arm;
  assign arm = ctl_we_i & start_bit_i;

  // R2: arming clears result and done flag
  p_arm_clears_r2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (ecc_reg_o == '0) && !done_o);

  // R5: packed code is the inverted concatenation of the two groups
  p_code_inverse_r5: assert property (@(posedge clk) disable iff (rst)
    code_o == ~{ecc_reg_o[HI_OFS+GW-1:HI_OFS], ecc_reg_o[GW-1:0]});

  // R7: no valid, no read, no arming -> result holds
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid_i && !rd_i && !arm) |=> $stable(ecc_reg_o));

  // R8: after a full sector, nothing moves until arm or read
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !rd_i && !arm) |=> $stable(ecc_reg_o) && done_o);

  // R9: a read clears the accumulation on the next cycle
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (ecc_reg_o == '0) && !done_o);
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(
  .DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_we_i   (ctl_we_i),
  .start_bit_i(ctl_wdata_i[nand_ecc_pkg::START_BIT]),
  .rd_i       (rd_i),
  .in_valid_i (in_valid_i),
  .ecc_reg_o  (ecc_reg_o),
  .code_o     (code_o),
  .done_o     (done_o)
);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic        rd_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic [31:0] ecc_reg_o;
  logic [23:0] code_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] sec [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_gen u_dut (
    .clk(clk), .rst(rst), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .rd_i(rd_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .ecc_reg_o(ecc_reg_o), .code_o(code_o), .done_o(done_o)
  );

  // kind: 0 constant fill (value idx[7:0]), 1 single set bit on 0x00,
  //       2 single cleared bit on 0xFF, 3 incrementing bytes (model result)
  typedef struct packed {
    logic [1:0]  kind;
    logic [8:0]  idx;
    logic [2:0]  bitp;
    logic        gaps;
    logic [23:0] exp;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'd0, 9'h0FF, 3'd0, 1'b0, 24'hFFFFFF},
    '{2'd0, 9'h000, 3'd0, 1'b1, 24'hFFFFFF},
    '{2'd1, 9'd0,   3'd0, 1'b0, 24'hFFF000},
    '{2'd1, 9'd511, 3'd7, 1'b0, 24'h000FFF},
    '{2'd1, 9'd5,   3'd3, 1'b1, 24'hFD402B},
    '{2'd2, 9'd100, 3'd6, 1'b0, 24'hCD9326},
    '{2'd1, 9'd256, 3'd1, 1'b0, 24'h7FE801},
    '{2'd3, 9'd0,   3'd0, 1'b1, 24'h000000}
  };

  function automatic logic [23:0] model_code();
    logic [11:0] one = '0, zero = '0, a;
    for (int i = 0; i < NB; i++)
      for (int b = 0; b < 8; b++)
        if (sec[i][b]) begin
          a = {i[8:0], b[2:0]};
          one ^= a;
          zero ^= ~a;
        end
    return ~{one, zero};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit gap);
    in_valid_i = 1'b1; in_data_i = d;
    @(negedge clk);
    in_valid_i = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] w);
    ctl_we_i = 1'b1; ctl_wdata_i = w;
    @(negedge clk);
    ctl_we_i = 1'b0; ctl_wdata_i = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [23:0] e;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reg", ecc_reg_o, 32'h0);
    chk("R1 code", {8'h0, code_o}, 32'h00FFFFFF);
    chk("R1 done", {31'h0, done_o}, 32'h0);

    // R2 not armed, and control write without bit 8 has no effect
    send_byte(8'h01, 0);
    arm(32'h0000_00FF);
    send_byte(8'h01, 0);
    send_byte(8'h80, 0);
    chk("R2 unarmed reg", ecc_reg_o, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 8; v++) begin
      for (int i = 0; i < NB; i++) begin
        case (VEC[v].kind)
          2'd0: sec[i] = VEC[v].idx[7:0];
          2'd1: sec[i] = 8'h00;
          2'd2: sec[i] = 8'hFF;
          default: sec[i] = i[7:0];
        endcase
      end
      if (VEC[v].kind == 2'd1) sec[VEC[v].idx][VEC[v].bitp] = 1'b1;
      if (VEC[v].kind == 2'd2) sec[VEC[v].idx][VEC[v].bitp] = 1'b0;
      e = (VEC[v].kind == 2'd3) ? model_code() : VEC[v].exp;
      chk("R3 bench model vs table", {8'h0, model_code()}, {8'h0, e});
      arm(32'h0000_0100);
      for (int i = 0; i < NB; i++) send_byte(sec[i], VEC[v].gaps);
      chk("R5 R6 code", {8'h0, code_o}, {8'h0, e});
      chk("R3 R4 reg layout", ecc_reg_o, {4'h0, ~e[23:12], 4'h0, ~e[11:0]});
      chk("R8 done after sector", {31'h0, done_o}, 32'h1);
      rd_i = 1'b1;
      held = ecc_reg_o;
      @(negedge clk);
      rd_i = 1'b0;
      chk("R9 read value", held, {4'h0, ~e[23:12], 4'h0, ~e[11:0]});
      chk("R9 cleared", ecc_reg_o, 32'h0);
    end

    // R8 done timing and limit
    arm(32'h0000_0100);
    send_byte(8'h01, 0);
    for (int i = 1; i < NB - 1; i++) send_byte(8'h00, 0);
    chk("R8 done low at 511", {31'h0, done_o}, 32'h0);
    send_byte(8'h00, 0);
    chk("R8 done high at 512", {31'h0, done_o}, 32'h1);
    send_byte(8'h80, 0);
    send_byte(8'h81, 0);
    chk("R8 extra bytes ignored", {8'h0, code_o}, 32'h00FFF000);
    // R5 byte order: spare byte 0 in [7:0]
    chk("R5 first byte", {24'h0, code_o[7:0]}, 32'h00);
    chk("R5 last byte", {24'h0, code_o[23:16]}, 32'hFF);

    // R7 idle cycles
    held = ecc_reg_o;
    repeat (5) @(negedge clk);
    chk("R7 idle stable", ecc_reg_o, held);

    // R9 byte in read cycle discarded, index restarts, still armed
    rd_i = 1'b1; in_valid_i = 1'b1; in_data_i = 8'h01;
    @(negedge clk);
    rd_i = 1'b0; in_valid_i = 1'b0;
    chk("R9 byte in read cycle dropped", ecc_reg_o, 32'h0);
    chk("R9 done cleared", {31'h0, done_o}, 32'h0);
    send_byte(8'h01, 1);
    chk("R9 R7 index restart", ecc_reg_o, 32'h0000_0FFF);

    // R10 restart mid-sector
    send_byte(8'hFF, 0);
    send_byte(8'h5A, 0);
    arm(32'h0000_0100);
    chk("R10 restart clears", ecc_reg_o, 32'h0);
    send_byte(8'h02, 0);
    chk("R10 index zero after restart", ecc_reg_o, 32'h0001_0FFE);

    finish_run();
  end
endmodule